// File: doc/BRIEF.md
# Frequency-Compensated Nanosecond Timer with Interval Pulses

This block keeps a 64-bit time-of-day count in nanoseconds. One of four reference tick inputs is chosen by a source field and acts as a tick enable. On every chosen tick a 32-bit addend is summed into a 32-bit phase accumulator. Only the carry out of that sum advances the time count, and each carry adds one programmed nominal clock period in nanoseconds. Software tunes the addend to trim the rate of the time base against its reference. A ceiling register clamps addend writes so the trim cannot pass a chosen bound.

A prescaler counts carries and produces a one-cycle output-clock strobe once every N carries. Two independent interval generators measure compensated time in nanoseconds and raise a pulse once per programmed interval. The first generator is normally set up for one pulse per second. Each pulse stays high for one output-clock period. Every register is loaded through a single-cycle write port.

Top module: `ptp_timer`

## Requirements
- R1: After a synchronous active-high reset the time count is 0, `nomTick`, `outTick`, `pulseA` and `pulseB` are low, the source field selects the system clock (code 1), the prescale value is 1, the nominal period is 10 ns, the addend is 0x8000_0000, the ceiling is 0xFFFF_FFFF and both interval registers are 0.
- R2: Register address 0, bits [1:0], picks the reference: code 0 external precision clock, 1 system clock, 2 transmit clock, 3 real-time clock. These map to `refTick` bits 0 to 3. A tick on any bit other than the selected one has no effect on the time count.
- R3: On each selected tick the active addend is added modulo 2^32 into the accumulator. When the sum carries, the time count grows by the period register (address 3) at that clock edge, and `nomTick` is high for the following cycle only.
- R4: A write to the addend register (address 1) stores the value clamped to the ceiling register (address 2). The stored value becomes active at the next accumulator carry after the write.
- R5: The prescaler (address 4) raises `outTick` for one cycle once every N carries, where N is the prescale value. A prescale of 0 acts as 1.
- R6: Interval generator A (address 5) fires at the carry where the nanoseconds elapsed since its last firing reach its register plus one nominal period. The excess is kept, so the next interval starts from the firing point. The register value in force at each carry is the one used.
- R7: A firing drives its pulse output high for exactly N subsequent carries, where N is the effective prescale value. A new firing reloads the count.
- R8: An interval register holding zero disables its generator: at each carry its pulse is forced low and its elapsed time is cleared.
- R9: Interval generator B (address 6) follows R6 to R8 independently of generator A and drives `pulseB`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 32 | Register write data |
| refTick | input | 4 | Reference tick enables, one per source code |
| todNs | output | 64 | Time of day in nanoseconds |
| nomTick | output | 1 | One-cycle strobe after each accumulator carry |
| outTick | output | 1 | One-cycle prescaled output-clock strobe |
| pulseA | output | 1 | Interval generator A pulse |
| pulseB | output | 1 | Interval generator B pulse |

## Verification
A register write and an accumulator carry can land on the same clock edge. In that case the carry must load the addend, and judge the interval comparisons, using the values that were present before the write. The bench provokes this with a burst of back-to-back addend writes and interval rewrites while ticks run every cycle, so some writes coincide with carries. A behavioural model applies each edge's carry effects first and the write second, and every output is compared with that model on every cycle.

// File: rtl/ptp_pkg.sv
package ptp_pkg;
  localparam int ADDR_W  = 3;
  localparam int NUM_IVL = 2;
  localparam int NUM_SRC = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_SRC    = 3'd0,
    REG_ADDEND = 3'd1,
    REG_CEIL   = 3'd2,
    REG_PERIOD = 3'd3,
    REG_PRESC  = 3'd4,
    REG_IVL0   = 3'd5,
    REG_IVL1   = 3'd6
  } regAddr_e;

  localparam logic [1:0] SRC_SYSTEM = 2'd1;

  typedef struct packed {
    logic               tick;
    logic [NUM_IVL-1:0] ivlEn;
  } ctlStrobe_t;
endpackage

// File: rtl/ptp_ctrl.sv
module ptp_ctrl
  import ptp_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          PRESC_W    = 16,
  parameter logic [31:0] ADDEND_RST = 32'h8000_0000,
  parameter logic [31:0] PERIOD_RST = 32'd10,
  parameter logic [15:0] PRESC_RST  = 16'd1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [NUM_SRC-1:0]             refTick,
  input  logic                           carry,
  output ctlStrobe_t                     strobe,
  output logic [DATA_W-1:0]              addendShadow,
  output logic [DATA_W-1:0]              ceilVal,
  output logic [DATA_W-1:0]              periodNs,
  output logic [PRESC_W-1:0]             prescEff,
  output logic [NUM_IVL-1:0][DATA_W-1:0] ivlPeriod,
  output logic                           outTick
);
  logic [1:0]         srcSel;
  logic [PRESC_W-1:0] prescReg;
  logic [PRESC_W-1:0] prescCnt;
  logic               wrapHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      srcSel       <= SRC_SYSTEM;
      addendShadow <= ADDEND_RST[DATA_W-1:0];
      ceilVal      <= '1;
      periodNs     <= PERIOD_RST[DATA_W-1:0];
      prescReg     <= PRESC_RST[PRESC_W-1:0];
      ivlPeriod    <= '0;
    end else if (wrEn) begin
      case (regAddr_e'(wrAddr))
        REG_SRC:    srcSel       <= wrData[1:0];
        REG_ADDEND: addendShadow <= (wrData > ceilVal) ? ceilVal : wrData;
        REG_CEIL:   ceilVal      <= wrData;
        REG_PERIOD: periodNs     <= wrData;
        REG_PRESC:  prescReg     <= wrData[PRESC_W-1:0];
        REG_IVL0:   ivlPeriod[0] <= wrData;
        REG_IVL1:   ivlPeriod[1] <= wrData;
        default:    ;
      endcase
    end
  end

  assign prescEff = (prescReg == '0) ? PRESC_W'(1) : prescReg;
  assign wrapHit  = (prescCnt >= prescEff - PRESC_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      prescCnt <= '0;
      outTick  <= 1'b0;
    end else begin
      outTick <= carry && wrapHit;
      if (carry) begin
        prescCnt <= wrapHit ? '0 : prescCnt + PRESC_W'(1);
      end
    end
  end

  assign strobe.tick = refTick[srcSel];

  for (genvar gi = 0; gi < NUM_IVL; gi++) begin : g_en
    assign strobe.ivlEn[gi] = (ivlPeriod[gi] != '0);
  end
endmodule

// File: rtl/ptp_interval.sv
module ptp_interval #(
  parameter int DATA_W  = 32,
  parameter int PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               carry,
  input  logic               enable,
  input  logic [DATA_W-1:0]  periodNs,
  input  logic [DATA_W-1:0]  ivlNs,
  input  logic [PRESC_W-1:0] prescEff,
  output logic               pulse
);
  localparam int ELAP_W = DATA_W + 2;

  logic [ELAP_W-1:0]  elapsed;
  logic [ELAP_W-1:0]  elapsedNext;
  logic [ELAP_W-1:0]  threshold;
  logic [PRESC_W-1:0] widthCnt;
  logic               fire;

  assign threshold   = {2'b00, ivlNs} + {2'b00, periodNs};
  assign elapsedNext = elapsed + {2'b00, periodNs};
  assign fire        = enable && (elapsedNext >= threshold);

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed  <= '0;
      widthCnt <= '0;
    end else if (carry) begin
      if (!enable) begin
        elapsed  <= '0;
        widthCnt <= '0;
      end else if (fire) begin
        elapsed  <= elapsedNext - threshold;
        widthCnt <= prescEff;
      end else begin
        elapsed <= elapsedNext;
        if (widthCnt != '0) widthCnt <= widthCnt - PRESC_W'(1);
      end
    end
  end

  assign pulse = (widthCnt != '0);
endmodule

// File: rtl/ptp_datapath.sv
module ptp_datapath
  import ptp_pkg::*;
#(
  parameter int          TOD_W      = 64,
  parameter int          DATA_W     = 32,
  parameter int          PRESC_W    = 16,
  parameter logic [31:0] ADDEND_RST = 32'h8000_0000
) (
  input  logic                           clk,
  input  logic                           rst,
  input  ctlStrobe_t                     strobe,
  input  logic [DATA_W-1:0]              addendShadow,
  input  logic [DATA_W-1:0]              periodNs,
  input  logic [PRESC_W-1:0]             prescEff,
  input  logic [NUM_IVL-1:0][DATA_W-1:0] ivlPeriod,
  output logic                           carry,
  output logic [TOD_W-1:0]               todNs,
  output logic                           nomTick,
  output logic [NUM_IVL-1:0]             pulse
);
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] addActive;
  logic [DATA_W:0]   sumW;

  assign sumW  = {1'b0, acc} + {1'b0, addActive};
  assign carry = strobe.tick && sumW[DATA_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      todNs     <= '0;
      nomTick   <= 1'b0;
      addActive <= ADDEND_RST[DATA_W-1:0];
    end else begin
      nomTick <= carry;
      if (strobe.tick) acc <= sumW[DATA_W-1:0];
      if (carry) begin
        todNs     <= todNs + {{(TOD_W-DATA_W){1'b0}}, periodNs};
        addActive <= addendShadow;
      end
    end
  end

  for (genvar gi = 0; gi < NUM_IVL; gi++) begin : g_ivl
    ptp_interval #(
      .DATA_W (DATA_W),
      .PRESC_W(PRESC_W)
    ) u_ivl (
      .clk     (clk),
      .rst     (rst),
      .carry   (carry),
      .enable  (strobe.ivlEn[gi]),
      .periodNs(periodNs),
      .ivlNs   (ivlPeriod[gi]),
      .prescEff(prescEff),
      .pulse   (pulse[gi])
    );
  end
endmodule

// File: rtl/ptp_timer.sv
module ptp_timer
  import ptp_pkg::*;
#(
  parameter int          TOD_W      = 64,
  parameter int          DATA_W     = 32,
  parameter int          PRESC_W    = 16,
  parameter logic [31:0] ADDEND_RST = 32'h8000_0000,
  parameter logic [31:0] PERIOD_RST = 32'd10,
  parameter logic [15:0] PRESC_RST  = 16'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [3:0]        refTick,
  output logic [TOD_W-1:0]  todNs,
  output logic              nomTick,
  output logic              outTick,
  output logic              pulseA,
  output logic              pulseB
);
  ctlStrobe_t                     strobe;
  logic [DATA_W-1:0]              addendShadow;
  logic [DATA_W-1:0]              ceilVal;
  logic [DATA_W-1:0]              periodNs;
  logic [PRESC_W-1:0]             prescEff;
  logic [NUM_IVL-1:0][DATA_W-1:0] ivlPeriod;
  logic                           carry;
  logic [NUM_IVL-1:0]             pulse;

  ptp_ctrl #(
    .DATA_W    (DATA_W),
    .PRESC_W   (PRESC_W),
    .ADDEND_RST(ADDEND_RST),
    .PERIOD_RST(PERIOD_RST),
    .PRESC_RST (PRESC_RST)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .refTick     (refTick),
    .carry       (carry),
    .strobe      (strobe),
    .addendShadow(addendShadow),
    .ceilVal     (ceilVal),
    .periodNs    (periodNs),
    .prescEff    (prescEff),
    .ivlPeriod   (ivlPeriod),
    .outTick     (outTick)
  );

  ptp_datapath #(
    .TOD_W     (TOD_W),
    .DATA_W    (DATA_W),
    .PRESC_W   (PRESC_W),
    .ADDEND_RST(ADDEND_RST)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .addendShadow(addendShadow),
    .periodNs    (periodNs),
    .prescEff    (prescEff),
    .ivlPeriod   (ivlPeriod),
    .carry       (carry),
    .todNs       (todNs),
    .nomTick     (nomTick),
    .pulse       (pulse)
  );

  assign pulseA = pulse[0];
  assign pulseB = pulse[1];
endmodule

// File: rtl/ptp_timer_chk.sv
module ptp_timer_chk #(
  parameter int TOD_W  = 64,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [2:0]        wrAddr,
  input logic [TOD_W-1:0]  todNs,
  input logic              nomTick,
  input logic              outTick,
  input logic              pulseA,
  input logic              pulseB,
  input logic              carry,
  input logic [DATA_W-1:0] periodNs,
  input logic [DATA_W-1:0] addendShadow,
  input logic [DATA_W-1:0] ceilVal,
  input logic [DATA_W-1:0] ivlA,
  input logic [DATA_W-1:0] ivlB
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  // R3: a carry strobe comes with exactly one period step of the time count
  p_tod_step_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    nomTick |-> todNs == $past(todNs) + {{(TOD_W-DATA_W){1'b0}}, $past(periodNs)});

  // R3: without a carry strobe the time count holds
  p_tod_hold_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    !nomTick |-> $stable(todNs));

  // R5: the output-clock strobe only accompanies a carry strobe
  p_outtick_on_carry_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    outTick |-> nomTick);

  // R4: a stored addend never exceeds the ceiling that applied at the write
  p_addend_clamp_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(wrEn) && $past(wrAddr) == 3'd1) |-> addendShadow <= $past(ceilVal));

  // R8: a disabled generator is low after any carry
  p_disabled_low_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(carry) && $past(ivlA) == '0) |-> !pulseA);

  p_disabled_low_b_r9: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(carry) && $past(ivlB) == '0) |-> !pulseB);

  // R6: a pulse only starts at a carry
  p_pulse_rise_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(pulseA) |-> $past(carry));

  p_pulse_rise_b_r9: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(pulseB) |-> $past(carry));
endmodule

bind ptp_timer ptp_timer_chk #(.TOD_W(TOD_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wrEn        (wrEn),
  .wrAddr      (wrAddr),
  .todNs       (todNs),
  .nomTick     (nomTick),
  .outTick     (outTick),
  .pulseA      (pulseA),
  .pulseB      (pulseB),
  .carry       (carry),
  .periodNs    (periodNs),
  .addendShadow(addendShadow),
  .ceilVal     (ceilVal),
  .ivlA        (ivlPeriod[0]),
  .ivlB        (ivlPeriod[1])
);

// File: tb/ptp_timer_bench.sv
module ptp_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  refTick = '0;
  logic [63:0] todNs;
  logic        nomTick, outTick, pulseA, pulseB;

  ptp_timer u_ptp_timer (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .refTick(refTick), .todNs(todNs), .nomTick(nomTick), .outTick(outTick),
    .pulseA(pulseA), .pulseB(pulseB)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  string phaseTag = "R1";

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // stimulus for the tick inputs
  logic [3:0] forceOn = '0, forceOff = '0;
  logic [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    #1;
    lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    refTick <= (lfsr[3:0] | forceOn) & ~forceOff;
  end

  // behavioural reference model
  logic [63:0] mTod;
  longint      mAcc, mAddAct, mAddSh, mCeil, mPer, mPresc, mPc;
  longint      mIvl[2], mEl[2], mCnt[2];
  int          mSrc;
  bit          mNom, mOut;

  always @(posedge clk) begin
    longint sum, pe, en, th;
    bit     cy;
    if (rst) begin
      mTod = 0; mAcc = 0; mAddAct = 64'h8000_0000; mAddSh = 64'h8000_0000;
      mCeil = 64'hFFFF_FFFF; mPer = 10; mPresc = 1; mPc = 0; mSrc = 1;
      for (int k = 0; k < 2; k++) begin mIvl[k] = 0; mEl[k] = 0; mCnt[k] = 0; end
      mNom = 0; mOut = 0;
    end else begin
      cy = 0;
      pe = (mPresc == 0) ? 1 : mPresc;
      if (refTick[mSrc]) begin
        sum  = mAcc + mAddAct;
        cy   = (sum >= 64'h1_0000_0000);
        mAcc = sum & 64'hFFFF_FFFF;
      end
      mNom = cy;
      mOut = 0;
      if (cy) begin
        mTod    = mTod + 64'(mPer);
        mAddAct = mAddSh;
        if (mPc >= pe - 1) begin mPc = 0; mOut = 1; end else mPc = mPc + 1;
        for (int k = 0; k < 2; k++) begin
          if (mIvl[k] == 0) begin
            mEl[k] = 0; mCnt[k] = 0;
          end else begin
            en = mEl[k] + mPer;
            th = mIvl[k] + mPer;
            if (en >= th) begin
              mEl[k] = en - th; mCnt[k] = pe;
            end else begin
              mEl[k] = en;
              if (mCnt[k] != 0) mCnt[k] = mCnt[k] - 1;
            end
          end
        end
      end
      if (wrEn) begin
        case (wrAddr)
          3'd0: mSrc = int'(wrData[1:0]);
          3'd1: mAddSh = (longint'(wrData) > mCeil) ? mCeil : longint'(wrData);
          3'd2: mCeil = longint'(wrData);
          3'd3: mPer = longint'(wrData);
          3'd4: mPresc = longint'(wrData[15:0]);
          3'd5: mIvl[0] = longint'(wrData);
          3'd6: mIvl[1] = longint'(wrData);
          default: ;
        endcase
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check({phaseTag, "/R3"}, "todNs", todNs, mTod);
      check({phaseTag, "/R3"}, "nomTick", 64'(nomTick), 64'(mNom));
      check({phaseTag, "/R5"}, "outTick", 64'(outTick), 64'(mOut));
      check({phaseTag, "/R6"}, "pulseA", 64'(pulseA), 64'(mCnt[0] != 0));
      check({phaseTag, "/R9"}, "pulseB", 64'(pulseB), 64'(mCnt[1] != 0));
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); #2;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); #2;
    wrEn = 1'b0;
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countHigh(int n, string which, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      if (which == "nom" && nomTick) cnt++;
      if (which == "out" && outTick) cnt++;
      if (which == "pa" && pulseA) cnt++;
    end
  endtask

  initial begin
    logic [63:0] held;
    int cnt;
    // R1: reset state, with the selected system tick held off
    forceOff = 4'b0010;
    forceOn  = 4'b1101;
    rst = 1'b1;
    cycles(4);
    #2 rst = 1'b0;
    cycles(10);
    check("R1", "todNs after reset", todNs, 64'd0);
    check("R1", "pulseA after reset", 64'(pulseA), 64'd0);
    check("R1", "pulseB after reset", 64'(pulseB), 64'd0);
    check("R2", "unselected ticks leave time", todNs, 64'd0);

    // R3 / R6 / R9: nominal running with both generators
    phaseTag = "R6";
    forceOff = 4'b0000; forceOn = 4'b0010;
    wr(3'd3, 32'd10);
    wr(3'd4, 32'd3);
    wr(3'd5, 32'd50);
    wr(3'd6, 32'd20);
    cycles(150);
    check("R3", "time advanced", 64'(todNs != 0), 64'd1);

    // R2: switch to the transmit tick, then hold it off
    phaseTag = "R2";
    wr(3'd0, 32'd2);
    forceOn = 4'b0000;
    cycles(100);
    forceOff = 4'b0100; forceOn = 4'b1011;
    cycles(3);
    held = todNs;
    cycles(20);
    check("R2", "time held while selected tick idle", todNs, held);

    // R4: clamp, and writes coinciding with carries
    phaseTag = "R4";
    wr(3'd0, 32'd1);
    forceOff = 4'b0000; forceOn = 4'b0010;
    wr(3'd2, 32'h4000_0000);
    wr(3'd1, 32'hFFFF_FFFF);
    cycles(8);
    countHigh(40, "nom", cnt);
    check("R4", "carries with clamped addend", 64'(cnt), 64'd10);
    for (int i = 0; i < 16; i++) wr(3'd1, 32'h1000_0000 + 32'(i) * 32'h0200_0000);
    for (int i = 0; i < 6; i++) wr(3'd6, 32'd20 + 32'(i) * 32'd10);
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd1, 32'h8000_0000);
    cycles(8);

    // R5: prescale zero acts as one
    phaseTag = "R5";
    wr(3'd4, 32'd0);
    cycles(8);
    countHigh(40, "out", cnt);
    check("R5", "outTick with prescale 0", 64'(cnt), 64'd20);

    // R7: wider pulses with prescale 5
    phaseTag = "R7";
    wr(3'd4, 32'd5);
    wr(3'd5, 32'd90);
    cycles(200);

    // R8: disable generator A
    phaseTag = "R8";
    wr(3'd5, 32'd0);
    cycles(4);
    countHigh(100, "pa", cnt);
    check("R8", "pulseA highs while disabled", 64'(cnt), 64'd0);
    phaseTag = "R6";
    wr(3'd5, 32'd30);
    cycles(100);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule